// File: doc/BRIEF.md
# Programmable Chip-Select Address Decoder

This block watches each bus cycle's address and its space type (memory or I/O) and checks them against a set of programmable regions. It drives active-low chip-select outputs for the regions that match. It also hands the bus sequencer the wait-state count and the "external ready required" flag of the selected region.

The regions are as follows:
- An upper memory region that ends at the top of the address space.
- A lower memory region that starts at address zero.
- A mid memory window split into four equal selects.
- Seven 256-byte peripheral blocks at fixed offsets from one programmable base, in either space.
- An internal control-register window, which always decodes as zero waits with no external ready.

Software programs six control words through a simple write port. A select's decode logic is switched on by writing its control words, whether or not its pin is used as a chip select.

Peripheral select 4 has no output pin, but it still supplies wait and ready settings. Peripheral selects 5 and 6 can be turned into latched address bits A1 and A2; in that mode their own decode is switched off. When several selects match at once, all of them assert. The lowest-numbered match supplies the configuration, and a conflict flag is raised if any matching configuration differs from it.

Top module: `cs_decoder`

## Requirements
- R1: After reset every region is disabled except the control window, which resets to I/O space with base field 0x0FF (I/O addresses 0x0FF00..0x0FFFF). All chip-select and pin outputs are high, and wait is 0 with ready-required 0 when nothing matches.
- R2: The upper and lower regions decode memory space only. The size code s (word bits [6:4]) gives a size of 1024<<s bytes. The lower region is address < size; the upper region is the top `size` bytes of the 20-bit space. Word bits are: [1:0] wait, [2] ready-required, [3] address-off.
- R3: The mid window (word index 2) decodes memory space. Address bits [19:14] are compared with word bits [15:10]. Mid select k asserts when address bits [13:12] equal k. Word bits [1:0] hold the wait count and bit [2] holds ready-required.
- R4: Peripheral select k (0..6) asserts when address bits [19:11] equal word 3 bits [15:7], address bits [10:8] equal k, and the space matches word 3 bit [4] (1 = I/O). Offset 7 matches nothing.
- R5: Upper and lower are enabled by any write to their own word (index 0 and 1). The mid selects need writes to both word 2 and the auxiliary word 4. The peripheral selects need writes to both word 3 and word 4. Writes to index 6 or 7 are ignored.
- R6: Peripheral select 4 has no pin, yet on a match it supplies the word 3 wait and ready settings.
- R7: With auxiliary bit [3] set, pins 5 and 6 output address bits 1 and 2 captured when `bus_start` is high at a clock edge, and hold them otherwise. Peripheral selects 5 and 6 then never match.
- R8: Wait codes are as follows. The 2-bit fields give 0..3. Peripheral selects 0..4 use the 3-bit word 3 field [2:0]: codes 0..3 give 0..3, and codes 4, 5, 6, 7 give 5, 7, 9, 15. Peripheral selects 5 and 6 use auxiliary bits [1:0].
- R9: `ext_rdy_req` follows the ready-required bit of the chosen select: word 3 bit [3] for peripheral selects 0..4, auxiliary bit [2] for selects 5 and 6.
- R10: A control-window hit raises `ctl_hit` and, when chosen, gives 0 waits and ready-required 0.
- R11: `addr_float` is high while the upper (or lower) select asserts and its address-off bit is set.
- R12: Every matching select asserts. The configuration comes from the lowest index in the order control, upper, lower, mid 0..3, peripheral 0..6. `cfg_conflict` is high when any other match has a different wait or ready setting.
- R13: With `bus_act` low nothing matches and every chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_idx | input | 3 | Control word index |
| cfg_wdata | input | 16 | Control word write data |
| bus_act | input | 1 | A bus cycle is in progress |
| bus_start | input | 1 | Address-valid strobe for latching A1/A2 |
| bus_addr | input | 20 | Bus cycle address |
| bus_io | input | 1 | 1 = I/O space, 0 = memory space |
| ucs_n | output | 1 | Upper region select |
| lcs_n | output | 1 | Lower region select |
| mcs_n | output | 4 | Mid window selects |
| pcs_n | output | 4 | Peripheral selects 0..3 |
| pin5_o | output | 1 | Peripheral select 5 or latched A1 |
| pin6_o | output | 1 | Peripheral select 6 or latched A2 |
| ctl_hit | output | 1 | Control window matched |
| any_hit | output | 1 | Some select matched |
| wait_cnt | output | 4 | Wait states of the chosen select |
| ext_rdy_req | output | 1 | Chosen select needs external ready |
| cfg_conflict | output | 1 | Overlapping selects disagree |
| addr_float | output | 1 | Address-off request from upper/lower |

## Verification
The decode path is combinational from the stored words to the outputs, so a wrong field position, compare or enable flag shows on the chip-select and wait outputs in the same cycle as the first access to the affected region. A wrong enable flag also shows there: the region stays silent after its writes, or answers before them. A wrong priority order or conflict comparison shows only when regions overlap, so overlapping programs are applied on purpose. The latched address pins are the only registered outputs, and an error there shows in the cycle after a start strobe or as drift while the strobe is low.

// File: rtl/cs_dec_pkg.sv
`timescale 1ns/1ps
// Shared constants, types and the wide wait-code mapping for the decoder.
// Assumes a fixed select ordering that also defines configuration priority.
package cs_dec_pkg;
    localparam int NSEL     = 14;   // control, upper, lower, 4 mid, 7 peripheral
    localparam int NMID     = 4;
    localparam int NPER     = 7;
    localparam int SEL_CTL  = 0;
    localparam int SEL_UP   = 1;
    localparam int SEL_LO   = 2;
    localparam int SEL_MID0 = 3;
    localparam int SEL_PER0 = SEL_MID0 + NMID;
    localparam int NREG     = 6;
    localparam int IDX_W    = 3;
    localparam int REG_UP   = 0;
    localparam int REG_LO   = 1;
    localparam int REG_MID  = 2;
    localparam int REG_PER  = 3;
    localparam int REG_AUX  = 4;
    localparam int REG_CTL  = 5;

    typedef struct packed {
        logic [3:0] waits;
        logic       rdy;
    } sel_cfg_t;

    // Maps a 3-bit wait code to a wait count: 0..3 literal, then 5, 7, 9, 15.
    function automatic logic [3:0] wait_from_code3(input logic [2:0] code);
        case (code)
            3'd4:    return 4'd5;
            3'd5:    return 4'd7;
            3'd6:    return 4'd9;
            3'd7:    return 4'd15;
            default: return {1'b0, code};
        endcase
    endfunction
endpackage

// File: rtl/cs_cfg_regs.sv
`timescale 1ns/1ps
// Control word storage with sticky "written" flags used as enables.
// Assumes writes land at the clock edge where cfg_we is high; unmapped indices are dropped.
module cs_cfg_regs
    import cs_dec_pkg::*;
#(
    parameter int              DATA_W  = 16,
    parameter logic [DATA_W-1:0] CTL_RST = 16'h0FF1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [IDX_W-1:0]              cfg_idx,
    input  logic [DATA_W-1:0]             cfg_wdata,
    output logic [NREG-1:0][DATA_W-1:0]   word_q,
    output logic [NREG-1:0]               seen_q
);

    // Store written words and remember which indices have ever been written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                word_q[i] <= (i == REG_CTL) ? CTL_RST : '0;
            end
            seen_q <= '0;
        end else if (cfg_we) begin
            for (int i = 0; i < NREG; i++) begin
                if (cfg_idx == IDX_W'(i)) begin
                    word_q[i] <= cfg_wdata;
                    seen_q[i] <= 1'b1;
                end
            end
        end
    end

    // R5: an enable flag only turns on in the cycle after a write strobe
    p_enable_by_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((seen_q & ~$past(seen_q)) != '0) |-> $past(cfg_we));

    // R5: once written, a region stays enabled until reset
    p_enable_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(seen_q) & ~seen_q) == '0));

endmodule

// File: rtl/cs_region_match.sv
`timescale 1ns/1ps
// Compares the bus address and space against every programmed region and
// produces a per-select hit vector plus each select's wait/ready settings.
// Assumes region words are stable during a cycle; decode is purely combinational.
module cs_region_match
    import cs_dec_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 16,
    parameter int MID_BLK_W = 12,
    parameter int PER_BLK_W = 8,
    parameter int CTL_BLK_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NREG-1:0][DATA_W-1:0] word_q,
    input  logic [NREG-1:0]             seen_q,
    input  logic                        bus_act,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_io,
    output logic [NSEL-1:0]             hit,
    output sel_cfg_t [NSEL-1:0]         cfg,
    output logic                        latch_mode,
    output logic                        noaddr_up,
    output logic                        noaddr_lo
);

    localparam int SIZE_UNIT  = 10;
    localparam int MID_SPAN_W = MID_BLK_W + $clog2(NMID);
    localparam int MB_W       = ADDR_W - MID_SPAN_W;
    localparam int PER_OFF_W  = 3;
    localparam int PER_SPAN_W = PER_BLK_W + PER_OFF_W;
    localparam int PB_W       = ADDR_W - PER_SPAN_W;
    localparam int CB_W       = ADDR_W - CTL_BLK_W;

    logic [DATA_W-1:0] up_w, lo_w, mid_w, per_w, aux_w, ctl_w;
    logic [ADDR_W:0]   up_span, lo_span;
    logic              up_in, lo_in, mid_in, per_in, ctl_in, mid_en, per_en;
    logic [$clog2(NMID)-1:0] mid_idx;
    logic [PER_OFF_W-1:0]    per_off;
    logic              cfg_unused;

    assign up_w  = word_q[REG_UP];
    assign lo_w  = word_q[REG_LO];
    assign mid_w = word_q[REG_MID];
    assign per_w = word_q[REG_PER];
    assign aux_w = word_q[REG_AUX];
    assign ctl_w = word_q[REG_CTL];

    // Region sizes for the edge regions from their 3-bit size codes.
    assign up_span = (ADDR_W+1)'(1) << (SIZE_UNIT + int'(up_w[6:4]));
    assign lo_span = (ADDR_W+1)'(1) << (SIZE_UNIT + int'(lo_w[6:4]));

    // Window membership tests for each region family.
    assign lo_in  = {1'b0, bus_addr} < lo_span;
    assign up_in  = {1'b0, ~bus_addr} < up_span;
    assign mid_in = bus_addr[ADDR_W-1:MID_SPAN_W] == mid_w[DATA_W-1 -: MB_W];
    assign per_in = (bus_addr[ADDR_W-1:PER_SPAN_W] == per_w[DATA_W-1 -: PB_W])
                  && (bus_io == per_w[4]);
    assign ctl_in = (bus_addr[ADDR_W-1:CTL_BLK_W] == ctl_w[DATA_W-1 -: CB_W])
                  && (bus_io == ctl_w[0]);
    assign mid_idx = bus_addr[MID_SPAN_W-1:MID_BLK_W];
    assign per_off = bus_addr[PER_SPAN_W-1:PER_BLK_W];
    assign mid_en  = seen_q[REG_MID] & seen_q[REG_AUX];
    assign per_en  = seen_q[REG_PER] & seen_q[REG_AUX];

    assign latch_mode = aux_w[3];
    assign noaddr_up  = up_w[3];
    assign noaddr_lo  = lo_w[3];

    // Control window, upper and lower selects.
    assign hit[SEL_CTL] = bus_act & ctl_in;
    assign hit[SEL_UP]  = bus_act & seen_q[REG_UP] & ~bus_io & up_in;
    assign hit[SEL_LO]  = bus_act & seen_q[REG_LO] & ~bus_io & lo_in;
    assign cfg[SEL_CTL] = '{waits: 4'd0, rdy: 1'b0};
    assign cfg[SEL_UP]  = '{waits: {2'b00, up_w[1:0]}, rdy: up_w[2]};
    assign cfg[SEL_LO]  = '{waits: {2'b00, lo_w[1:0]}, rdy: lo_w[2]};

    // Mid selects share one word; each decodes one quarter of the window.
    for (genvar k = 0; k < NMID; k++) begin : g_mid
        assign hit[SEL_MID0+k] = bus_act & mid_en & ~bus_io & mid_in
                               & (mid_idx == $clog2(NMID)'(k));
        assign cfg[SEL_MID0+k] = '{waits: {2'b00, mid_w[1:0]}, rdy: mid_w[2]};
    end

    // Peripheral selects: low five use the wide wait code, top two the aux word.
    for (genvar k = 0; k < NPER; k++) begin : g_per
        assign hit[SEL_PER0+k] = bus_act & per_en & per_in
                               & (per_off == PER_OFF_W'(k))
                               & ((k < 5) ? 1'b1 : ~latch_mode);
        if (k < 5) begin : g_wide
            assign cfg[SEL_PER0+k] = '{waits: wait_from_code3(per_w[2:0]), rdy: per_w[3]};
        end else begin : g_narrow
            assign cfg[SEL_PER0+k] = '{waits: {2'b00, aux_w[1:0]}, rdy: aux_w[2]};
        end
    end

    assign cfg_unused = ^{up_w[DATA_W-1:7], lo_w[DATA_W-1:7], mid_w[DATA_W-MB_W-1:3],
                          per_w[DATA_W-PB_W-1:5], aux_w[DATA_W-1:4],
                          ctl_w[DATA_W-CB_W-1:1], seen_q[REG_CTL]};

    // R13: an idle bus produces no match at all
    p_idle_no_hit_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_act |-> (hit == '0));

    // R3: at most one mid select answers a given address
    p_mid_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit[SEL_MID0 +: NMID]));

    // R2: edge regions never answer in I/O space
    p_edge_mem_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_io |-> !(hit[SEL_UP] || hit[SEL_LO]));

endmodule

// File: rtl/cs_cfg_merge.sv
`timescale 1ns/1ps
// Picks the configuration of the lowest-index matching select and flags
// any other match whose wait/ready settings differ from it.
// Assumes the select index order is the priority order.
module cs_cfg_merge
    import cs_dec_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSEL-1:0]     hit,
    input  sel_cfg_t [NSEL-1:0] cfg,
    output logic [3:0]          wait_cnt,
    output logic                ext_rdy_req,
    output logic                cfg_conflict,
    output logic                any_hit
);

    sel_cfg_t chosen;

    // Priority pick: scanning downward leaves the lowest matching index.
    always_comb begin
        chosen  = '0;
        any_hit = 1'b0;
        for (int i = NSEL-1; i >= 0; i--) begin
            if (hit[i]) begin
                chosen  = cfg[i];
                any_hit = 1'b1;
            end
        end
    end

    // Disagreement check across all matches against the chosen settings.
    always_comb begin
        cfg_conflict = 1'b0;
        for (int i = 0; i < NSEL; i++) begin
            if (hit[i] && (cfg[i] != chosen)) cfg_conflict = 1'b1;
        end
    end

    assign wait_cnt    = chosen.waits;
    assign ext_rdy_req = chosen.rdy;

    // R12: a conflict needs at least two simultaneous matches
    p_conflict_two_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_conflict |-> ($countones(hit) > 1));

    // R1: with no match the sequencer sees zero waits and no ready demand
    p_idle_cfg_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !any_hit |-> (wait_cnt == 4'd0 && !ext_rdy_req));

endmodule

// File: rtl/cs_decoder.sv
`timescale 1ns/1ps
// Top of the chip-select decoder: control words, region match, priority merge,
// and the optional latched A1/A2 outputs on the pins of peripheral selects 5/6.
// Assumes bus_start marks the cycle whose address bits 2:1 should be captured.
module cs_decoder
    import cs_dec_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_idx,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              bus_act,
    input  logic              bus_start,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_io,
    output logic              ucs_n,
    output logic              lcs_n,
    output logic [3:0]        mcs_n,
    output logic [3:0]        pcs_n,
    output logic              pin5_o,
    output logic              pin6_o,
    output logic              ctl_hit,
    output logic              any_hit,
    output logic [3:0]        wait_cnt,
    output logic              ext_rdy_req,
    output logic              cfg_conflict,
    output logic              addr_float
);

    logic [NREG-1:0][DATA_W-1:0] word_q;
    logic [NREG-1:0]             seen_q;
    logic [NSEL-1:0]             hit;
    sel_cfg_t [NSEL-1:0]         cfg;
    logic                        latch_mode, noaddr_up, noaddr_lo;
    logic                        a1_q, a2_q;

    cs_cfg_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .word_q(word_q), .seen_q(seen_q)
    );

    cs_region_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
        .clk(clk), .rst_n(rst_n), .word_q(word_q), .seen_q(seen_q),
        .bus_act(bus_act), .bus_addr(bus_addr), .bus_io(bus_io),
        .hit(hit), .cfg(cfg), .latch_mode(latch_mode),
        .noaddr_up(noaddr_up), .noaddr_lo(noaddr_lo)
    );

    cs_cfg_merge u_merge (
        .clk(clk), .rst_n(rst_n), .hit(hit), .cfg(cfg),
        .wait_cnt(wait_cnt), .ext_rdy_req(ext_rdy_req),
        .cfg_conflict(cfg_conflict), .any_hit(any_hit)
    );

    // Capture address bits 2:1 on each start strobe for the latched-pin mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a1_q <= 1'b0;
            a2_q <= 1'b0;
        end else if (bus_start) begin
            a1_q <= bus_addr[1];
            a2_q <= bus_addr[2];
        end
    end

    assign ucs_n   = ~hit[SEL_UP];
    assign lcs_n   = ~hit[SEL_LO];
    assign mcs_n   = ~hit[SEL_MID0 +: NMID];
    assign pcs_n   = ~hit[SEL_PER0 +: 4];
    assign pin5_o  = latch_mode ? a1_q : ~hit[SEL_PER0+5];
    assign pin6_o  = latch_mode ? a2_q : ~hit[SEL_PER0+6];
    assign ctl_hit = hit[SEL_CTL];
    assign addr_float = (hit[SEL_UP] & noaddr_up) | (hit[SEL_LO] & noaddr_lo);

    // R11: address-off only accompanies an asserted upper or lower select
    p_float_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
        addr_float |-> (!ucs_n || !lcs_n));

    // R7: latched pins follow the address presented with the start strobe
    p_latch_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_mode && bus_start) |=> (!latch_mode || pin5_o == $past(bus_addr[1])));

    // R7: without a strobe the latched pins hold their value
    p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_mode && !bus_start) |=> (!latch_mode || $stable({pin6_o, pin5_o})));

endmodule

// File: tb/cs_decoder_test.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table walked by one loop, then directed tests.
module cs_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [15:0] cfg_wdata = '0;
    logic        bus_act = 1'b0;
    logic        bus_start = 1'b0;
    logic [19:0] bus_addr = '0;
    logic        bus_io = 1'b0;
    logic        ucs_n, lcs_n, pin5_o, pin6_o, ctl_hit, any_hit;
    logic        ext_rdy_req, cfg_conflict, addr_float;
    logic [3:0]  mcs_n, pcs_n, wait_cnt;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    cs_decoder uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .bus_act(bus_act), .bus_start(bus_start),
        .bus_addr(bus_addr), .bus_io(bus_io), .ucs_n(ucs_n), .lcs_n(lcs_n),
        .mcs_n(mcs_n), .pcs_n(pcs_n), .pin5_o(pin5_o), .pin6_o(pin6_o),
        .ctl_hit(ctl_hit), .any_hit(any_hit), .wait_cnt(wait_cnt),
        .ext_rdy_req(ext_rdy_req), .cfg_conflict(cfg_conflict),
        .addr_float(addr_float)
    );

    // Vector: {addr[19:0], io, expected select index (15 = none), wait, rdy, float}
    localparam int NV = 17;
    localparam logic [30:0] VEC [0:NV-1] = '{
        {20'hFF800, 1'b0, 4'd1,  4'd2, 1'b1, 1'b1},  // R2 upper, R11 float
        {20'hFEFFF, 1'b0, 4'd15, 4'd0, 1'b0, 1'b0},  // R2 just below upper
        {20'h00100, 1'b0, 4'd2,  4'd1, 1'b0, 1'b0},  // R2 lower
        {20'h003FF, 1'b0, 4'd2,  4'd1, 1'b0, 1'b0},  // R2 lower top byte
        {20'h00400, 1'b0, 4'd15, 4'd0, 1'b0, 1'b0},  // R2 past lower
        {20'h00100, 1'b1, 4'd15, 4'd0, 1'b0, 1'b0},  // R2 I/O space ignored
        {20'h08000, 1'b0, 4'd3,  4'd3, 1'b0, 1'b0},  // R3 mid 0
        {20'h0B123, 1'b0, 4'd6,  4'd3, 1'b0, 1'b0},  // R3 mid 3
        {20'h0C000, 1'b0, 4'd15, 4'd0, 1'b0, 1'b0},  // R3 past mid window
        {20'h10000, 1'b0, 4'd7,  4'd7, 1'b1, 1'b0},  // R4 periph 0
        {20'h10355, 1'b0, 4'd10, 4'd7, 1'b1, 1'b0},  // R4 periph 3
        {20'h10400, 1'b0, 4'd11, 4'd7, 1'b1, 1'b0},  // R6 periph 4, no pin
        {20'h10500, 1'b0, 4'd12, 4'd1, 1'b0, 1'b0},  // R4 periph 5
        {20'h10600, 1'b0, 4'd13, 4'd1, 1'b0, 1'b0},  // R4 periph 6
        {20'h10700, 1'b0, 4'd15, 4'd0, 1'b0, 1'b0},  // R4 offset 7
        {20'h10000, 1'b1, 4'd15, 4'd0, 1'b0, 1'b0},  // R4 wrong space
        {20'h0FF10, 1'b1, 4'd0,  4'd0, 1'b0, 1'b0}   // R10 control window
    };

    localparam logic [3:0] WT3 [0:7] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd5, 4'd7, 4'd9, 4'd15};

    task automatic wr(input logic [2:0] idx, input logic [15:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic drive(input logic act, input logic [19:0] a, input logic io);
        @(negedge clk);
        bus_act = act; bus_addr = a; bus_io = io;
        #5;
    endtask

    // Compare every decode output against what the hit set h implies.
    task automatic check_bus(input string req, input logic [13:0] h, input logic [3:0] wt,
                             input logic rdy, input logic conf, input logic flt);
        logic [20:0] got, exp;
        got = {ucs_n, lcs_n, mcs_n, pcs_n, pin5_o, pin6_o, ctl_hit, any_hit,
               wait_cnt, ext_rdy_req, cfg_conflict, addr_float};
        exp = {~h[1], ~h[2], ~h[6:3], ~h[10:7], ~h[12], ~h[13], h[0], |h,
               wt, rdy, conf, flt};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s addr=%h: got %h expected %h", req, bus_addr, got, exp);
        end
    endtask

    task automatic check_lat(input string req, input logic p5, input logic p6,
                             input logic anyh, input logic [3:0] wt);
        logic [6:0] got, exp;
        got = {pin5_o, pin6_o, any_hit, wait_cnt};
        exp = {p5, p6, anyh, wt};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [13:0] one(input int i);
        return (i == 15) ? 14'd0 : (14'd1 << i);
    endfunction

    initial begin : watchdog
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, nothing enabled but the control window
        drive(1'b1, 20'h00100, 1'b0);
        check_bus("R1 lower disabled after reset", 14'd0, 4'd0, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 20'hFF800, 1'b0);
        check_bus("R1 upper disabled after reset", 14'd0, 4'd0, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 20'h0FF10, 1'b1);
        check_bus("R1 R10 control window at reset", one(0), 4'd0, 1'b0, 1'b0, 1'b0);

        // R5: edge regions enable on their own writes; mid/periph wait for aux
        wr(3'd0, 16'h002E);
        wr(3'd1, 16'h0001);
        drive(1'b1, 20'hFF800, 1'b0);
        check_bus("R5 upper enabled by write", one(1), 4'd2, 1'b1, 1'b0, 1'b1);
        wr(3'd2, 16'h0803);
        wr(3'd3, 16'h100D);
        drive(1'b1, 20'h08000, 1'b0);
        check_bus("R5 mid waits for aux write", 14'd0, 4'd0, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 20'h10000, 1'b0);
        check_bus("R5 periph waits for aux write", 14'd0, 4'd0, 1'b0, 1'b0, 1'b0);
        wr(3'd6, 16'hFFFF);
        wr(3'd7, 16'hFFFF);
        drive(1'b1, 20'h08000, 1'b0);
        check_bus("R5 unmapped index ignored", 14'd0, 4'd0, 1'b0, 1'b0, 1'b0);
        wr(3'd4, 16'h0001);

        // Table walk over the programmed regions
        for (int i = 0; i < NV; i++) begin
            logic [30:0] v;
            v = VEC[i];
            drive(1'b1, v[30:11], v[10]);
            check_bus($sformatf("table vector %0d", i), one(int'(v[9:6])),
                      v[5:2], v[1], 1'b0, v[0]);
        end

        // R13: idle bus decodes nothing
        drive(1'b0, 20'hFF800, 1'b0);
        check_bus("R13 idle bus", 14'd0, 4'd0, 1'b0, 1'b0, 1'b0);

        // R8: every 3-bit wait code on periph 0
        for (int c = 0; c < 8; c++) begin
            wr(3'd3, 16'h1008 | 16'(c));
            drive(1'b1, 20'h10000, 1'b0);
            check_bus($sformatf("R8 wait code %0d", c), one(7), WT3[c], 1'b1, 1'b0, 1'b0);
        end

        // R9: ready-required bit cleared
        wr(3'd3, 16'h1005);
        drive(1'b1, 20'h10200, 1'b0);
        check_bus("R9 ready not required", one(9), 4'd7, 1'b0, 1'b0, 1'b0);
        wr(3'd3, 16'h100D);

        // R12: overlaps; lowest index wins, conflict on disagreement
        wr(3'd1, 16'h0071);
        drive(1'b1, 20'h08000, 1'b0);
        check_bus("R12 lower over mid differing", one(2) | one(3), 4'd1, 1'b0, 1'b1, 1'b0);
        wr(3'd1, 16'h0073);
        drive(1'b1, 20'h08000, 1'b0);
        check_bus("R12 lower over mid agreeing", one(2) | one(3), 4'd3, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 20'h10000, 1'b0);
        check_bus("R12 lower over periph", one(2) | one(7), 4'd3, 1'b0, 1'b1, 1'b0);
        wr(3'd1, 16'h007B);
        drive(1'b1, 20'h10000, 1'b0);
        check_bus("R11 address-off during overlap", one(2) | one(7), 4'd3, 1'b0, 1'b1, 1'b1);
        wr(3'd1, 16'h0001);

        // R7: latched address bits on pins 5/6
        wr(3'd4, 16'h0009);
        @(negedge clk);
        bus_act = 1'b1; bus_addr = 20'h10502; bus_io = 1'b0; bus_start = 1'b1;
        @(negedge clk);
        bus_start = 1'b0;
        #5;
        check_lat("R7 capture A1=1 A2=0, periph 5 silent", 1'b1, 1'b0, 1'b0, 4'd0);
        drive(1'b1, 20'h10604, 1'b0);
        check_lat("R7 hold without strobe, periph 6 silent", 1'b1, 1'b0, 1'b0, 4'd0);
        @(negedge clk);
        bus_addr = 20'h00004; bus_start = 1'b1;
        @(negedge clk);
        bus_start = 1'b0;
        #5;
        check_lat("R7 capture A1=0 A2=1 with lower hit", 1'b0, 1'b1, 1'b1, 4'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule